// File: doc/BRIEF.md
# Ordered Key Access Gate

This block guards a protected information region behind a write-only control register. Software opens the region by writing three fixed 32-bit key words to the register, one after another. The block follows how far the writes have advanced through that sequence. Once the last word is accepted, it raises a grant signal. The grant signal gates read and write traffic to the protected region elsewhere in the chip.

While access is open, the next write closes it again, whatever value it carries. Reads of the register always return zero, so software cannot use a read-back to learn the keys or how far the sequence has advanced. Bus decoding and the protected memory are outside this block. The block sees only a write strobe that is already decoded, the write data, and a reset.

Top module: `info_key_gate`

## Requirements
- R1: While the reset is asserted, and right after it is released, `grant` is 0 and no sequence progress is held. Asserting `rst_n` low while access is open drops `grant` at once.
- R2: The writes 0x3A7F5CA3, then 0xA1E34F20, then 0x9608B2C1, with no other write between them, set `grant` to 1. The change happens on the clock edge that samples the third write. `grant` stays 0 after the first and second words.
- R3: A write that does not match the next expected key word returns the tracker to its start. If that wrong write is not the first key word, the full three-word sequence is needed again before `grant` rises.
- R4: A wrong write whose value equals the first key word, 0x3A7F5CA3, counts as the first step of a new sequence. It does this at any point while access is closed.
- R5: While `grant` is 1, a write of any value clears `grant` on the next clock edge and leaves no progress. This holds even when the value is a key word.
- R6: `rd_data` is all zeros at all times, whether access is open or closed.
- R7: Cycles with `wr_en` low leave both the progress and `grant` unchanged, whatever value `wr_data` holds.
- R8: Once set, `grant` stays 1 for as long as no write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the access register, one write per cycle |
| wr_data | input | 32 | Write data |
| grant | output | 1 | High while access to the protected region is open |
| rd_data | output | 32 | Read data of the access register, always zero |

## Verification
Progress through the sequence cannot be seen at the ports until it affects `grant`. A wrong internal step count therefore shows up only as a grant that rises one key write too early or too late, or not at all. The tests walk the key words with wrong words placed after each step, with a repeated first word, and with idle gaps between writes. Each of these faults then appears at `grant` within one cycle of the write that ends the sequence. A relock fault appears on the cycle after the closing write, or after a later key sequence that should not have reopened access.

// File: rtl/info_key_pkg.sv
package info_key_pkg;
  localparam int unsigned KEY_W    = 32;
  localparam int unsigned NUM_KEYS = 3;
  localparam int unsigned STEP_W   = $clog2(NUM_KEYS + 1);

  // index 0 is the word that must be written first
  localparam logic [NUM_KEYS-1:0][KEY_W-1:0] KEY_SEQ = {
    32'h9608_B2C1,
    32'hA1E3_4F20,
    32'h3A7F_5CA3
  };
endpackage

// File: rtl/info_key_rst_sync.sv
module info_key_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/info_key_match.sv
module info_key_match
  import info_key_pkg::*;
(
  input  logic [KEY_W-1:0]    wr_data,
  output logic [NUM_KEYS-1:0] hit
);
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_cmp
    assign hit[k] = (wr_data == KEY_SEQ[k]);
  end
endmodule

// File: rtl/info_key_seq.sv
module info_key_seq
  import info_key_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [NUM_KEYS-1:0] hit,
  output logic [STEP_W-1:0]   step,
  output logic                open
);
  localparam logic [STEP_W-1:0] STEP_OPEN  = STEP_W'(NUM_KEYS);
  localparam logic [STEP_W-1:0] STEP_FIRST = STEP_W'(1);

  logic [STEP_W-1:0] step_q, step_nxt;
  logic              want_hit;

  always_comb begin
    want_hit = 1'b0;
    for (int k = 0; k < NUM_KEYS; k++) begin
      if (step_q == STEP_W'(k)) want_hit = hit[k];
    end
  end

  always_comb begin
    step_nxt = step_q;
    if (step_q == STEP_OPEN)  step_nxt = '0;
    else if (want_hit)        step_nxt = step_q + STEP_FIRST;
    else if (hit[0])          step_nxt = STEP_FIRST;
    else                      step_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     step_q <= '0;
    else if (wr_en) step_q <= step_nxt;
  end

  assign step = step_q;
  assign open = (step_q == STEP_OPEN);
endmodule

// File: rtl/info_key_gate.sv
module info_key_gate
  import info_key_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_data,
  output logic             grant,
  output logic [KEY_W-1:0] rd_data
);
  logic                rst_q_n;
  logic [NUM_KEYS-1:0] key_hit;
  logic [STEP_W-1:0]   seq_step;

  info_key_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  info_key_match u_match (
    .wr_data (wr_data),
    .hit     (key_hit)
  );

  info_key_seq u_seq (
    .clk   (clk),
    .rst_n (rst_q_n),
    .wr_en (wr_en),
    .hit   (key_hit),
    .step  (seq_step),
    .open  (grant)
  );

  assign rd_data = '0;
endmodule

// File: rtl/info_key_gate_chk.sv
module info_key_gate_chk
  import info_key_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [KEY_W-1:0] wr_data,
  input logic             grant,
  input logic [STEP_W-1:0] step
);
  assert_grant_on_last_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> ($past(wr_en) && $past(wr_data) == KEY_SEQ[NUM_KEYS-1]
                      && $past(step) == STEP_W'(NUM_KEYS-1)));

  assert_wrong_word_resets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !grant && wr_data != KEY_SEQ[0] && wr_data != KEY_SEQ[step]) |=> (step == '0));

  assert_first_key_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !grant && wr_data == KEY_SEQ[0]
     && !(step == '0 && wr_data == KEY_SEQ[step])) |=> (step == STEP_W'(1)));

  assert_any_write_relocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && wr_en) |=> (!grant && step == '0));

  assert_idle_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(step) && $stable(grant)));

  assert_grant_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !wr_en) |=> grant);
endmodule

bind info_key_gate info_key_gate_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_q_n),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .grant   (grant),
  .step    (seq_step)
);

// File: tb/info_key_gate_tb.sv
module info_key_gate_tb;
  localparam logic [31:0] K0  = 32'h3A7F_5CA3;
  localparam logic [31:0] K1  = 32'hA1E3_4F20;
  localparam logic [31:0] K2  = 32'h9608_B2C1;
  localparam logic [31:0] BAD = 32'h1234_5678;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        grant;
  logic [31:0] rd_data;

  int n_run;
  int n_fail;
  bit done;

  info_key_gate u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .grant   (grant),
    .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = BAD;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 grant after reset", {31'd0, grant}, 32'd1 - 32'd1);
    check("R6 rd_data locked", rd_data, 32'd0);
  endtask

  task automatic t_unlock();
    do_reset();
    wr(K0); check("R2 after first key", {31'd0, grant}, 32'd0);
    wr(K1); check("R2 after second key", {31'd0, grant}, 32'd0);
    wr(K2); check("R2 after third key", {31'd0, grant}, 32'd1);
    check("R6 rd_data open", rd_data, 32'd0);
    repeat (6) @(negedge clk);
    check("R8 grant held idle", {31'd0, grant}, 32'd1);
  endtask

  task automatic t_relock();
    do_reset();
    wr(K0); wr(K1); wr(K2);
    wr(K0); check("R5 relock on key write", {31'd0, grant}, 32'd0);
    wr(K1); wr(K2); check("R5 relock gives no progress", {31'd0, grant}, 32'd0);
    wr(K0); wr(K1); wr(K2);
    wr(BAD); check("R5 relock on junk write", {31'd0, grant}, 32'd0);
  endtask

  task automatic t_wrong();
    do_reset();
    wr(K0); wr(BAD); wr(K1); wr(K2);
    check("R3 wrong after step one", {31'd0, grant}, 32'd0);
    wr(K0); wr(K1); wr(BAD); wr(K2);
    check("R3 wrong after step two", {31'd0, grant}, 32'd0);
    wr(K1); wr(K2);
    check("R3 partial sequence", {31'd0, grant}, 32'd0);
  endtask

  task automatic t_restart();
    do_reset();
    wr(K0); wr(K0); wr(K1); wr(K2);
    check("R4 repeated first key", {31'd0, grant}, 32'd1);
    wr(BAD);
    wr(K0); wr(K1); wr(K0); wr(K1); wr(K2);
    check("R4 first key after step two", {31'd0, grant}, 32'd1);
  endtask

  task automatic t_gaps();
    do_reset();
    wr(K0);
    wr_data = K2; repeat (4) @(negedge clk);
    wr(K1);
    wr_data = K0; repeat (3) @(negedge clk);
    check("R7 idle keeps locked", {31'd0, grant}, 32'd0);
    wr(K2);
    check("R7 gaps keep progress", {31'd0, grant}, 32'd1);
    wr_data = BAD; repeat (3) @(negedge clk);
    check("R7 idle keeps open", {31'd0, grant}, 32'd1);
  endtask

  task automatic t_reset_open();
    do_reset();
    wr(K0); wr(K1); wr(K2);
    #3 rst_n = 1'b0;
    #2 check("R1 async reset drops grant", {31'd0, grant}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    wr(K1); wr(K2);
    check("R1 no progress after reset", {31'd0, grant}, 32'd0);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    t_reset();
    t_unlock();
    t_relock();
    t_wrong();
    t_restart();
    t_gaps();
    t_reset_open();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("[TB] FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule